// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Error Flags

This block receives asynchronous serial characters from a single line that idles at mark (logic 1). It runs from a sub-bit tick at sixteen times the bit rate. The character format comes from a shared mode setting: a character length of 5 to 8 data bits, optional parity, and even or odd parity. A falling edge on an idle line is taken as a possible start bit and is confirmed at its midpoint. The receiver then samples the data bits least significant first. If parity is enabled it samples the parity bit next, and it ends by sampling the stop bit.

A finished character is placed in a holding register, and a ready flag tells the host that it is waiting. The host takes the character by pulsing a read strobe. Framing, overrun and parity errors are kept as sticky flags. A later good character does not clear them; only an explicit error-clear command or reset does. A line held at space for longer than one character (a break) shows up as a framing error. After any framing error the receiver waits for the line to return to mark before it looks for a new start bit.

Top module: `async_rx_sticky`

## Requirements
- R1: Frame format: a start bit at 0, then the data bits with the least significant first, then an optional parity bit, then a stop bit at 1, each bit lasting 16 ticks. The character length code is `char_len_i`: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. `data_o` holds the character right-aligned, with its unused upper bits at zero.
- R2: A low level seen on a tick while idle is confirmed 8 ticks later. If the line is back at 1 at that point, the receiver returns to idle and delivers no character.
- R3: With `par_en_i` = 1, the parity bit is checked: `par_even_i` = 1 means even parity and 0 means odd parity, counted over the data bits and the parity bit together. A mismatch sets the parity flag. With `par_en_i` = 0, no parity bit is expected and the parity flag is never set.
- R4: Each error flag stays set through later error-free characters. Only `err_clr_i` or reset clears it. An error detected in the same cycle as `err_clr_i` wins.
- R5: Each completed character sets the ready flag and loads `data_o`.
- R6: A `rd_i` pulse while ready clears the ready flag, unless a new character completes in the same cycle.
- R7: A character that completes while the ready flag is set and `rd_i` is low sets the overrun flag. The new character replaces the old one in `data_o`.
- R8: While `rx_en_i` is 0, the receiver stays idle and delivers no characters.
- R9: A stop bit sampled at 0 sets the framing flag. A break, meaning the line held at 0 for longer than a character, is therefore reported as a framing error.
- R10: After a framing error, no new start bit is accepted until the line has returned to 1. A long break therefore yields exactly one character and no overrun.
- R11: `status_o` bit 5 is the framing flag, bit 4 the overrun flag, bit 3 the parity flag, and bit 1 the ready flag. All other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Receiver enable |
| tick_i | input | 1 | Sub-bit enable at 16x the bit rate |
| line_i | input | 1 | Serial input line, 1 is mark |
| char_len_i | input | 2 | Character length code (5 to 8 bits) |
| par_en_i | input | 1 | Parity bit present and checked |
| par_even_i | input | 1 | 1 selects even parity, 0 selects odd |
| rd_i | input | 1 | Host takes the held character |
| err_clr_i | input | 1 | Clears all three error flags |
| data_o | output | 8 | Held character, right-aligned |
| status_o | output | 8 | Ready flag and the three error flags |

## Verification
A wrong bit counter or a wrong sampling phase shows up after a single character as shifted or truncated bits in `data_o`, or as a spurious framing flag. A receiver that fails to wait for mark after a break is exposed the moment that break ends: the extra characters it delivers raise the overrun flag. Flags that are not sticky reveal themselves on the first good character after an error. A broken ready flag is exposed by the very next read strobe or the very next character.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP,
    S_WAIT
  } rx_state_e;
endpackage

// File: rtl/async_rx_sync.sv
module async_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '1;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/async_rx_frame.sv
module async_rx_frame
  import async_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       tick_i,
  input  logic       line_i,
  input  logic [1:0] len_i,
  input  logic       par_en_i,
  input  logic       par_even_i,
  output logic       done_o,
  output logic [7:0] data_o,
  output logic       fe_o,
  output logic       pe_o
);
  localparam int SUBW = $clog2(OVS);
  localparam logic [SUBW-1:0] SUB_HALF = SUBW'(OVS / 2 - 1);
  localparam logic [SUBW-1:0] SUB_LAST = SUBW'(OVS - 1);

  rx_state_e      state_q;
  logic [SUBW-1:0] sub_q;
  logic [2:0]     cnt_q;
  logic [7:0]     sh_q;
  logic           par_q;
  logic [2:0]     last_idx;
  logic [7:0]     aligned;
  logic           exp_par;

  assign last_idx = 3'd4 + {1'b0, len_i};
  assign aligned  = sh_q >> (2'd3 - len_i);
  assign exp_par  = par_even_i ? ^aligned : ~^aligned;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      sub_q   <= '0;
      cnt_q   <= '0;
      sh_q    <= '0;
      par_q   <= 1'b0;
      done_o  <= 1'b0;
      data_o  <= '0;
      fe_o    <= 1'b0;
      pe_o    <= 1'b0;
    end else if (!en_i) begin
      state_q <= S_IDLE;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        S_IDLE: if (tick_i && !line_i) begin
          state_q <= S_START;
          sub_q   <= '0;
        end
        S_START: if (tick_i) begin
          if (sub_q == SUB_HALF) begin
            sub_q   <= '0;
            cnt_q   <= '0;
            state_q <= line_i ? S_IDLE : S_DATA;
          end else sub_q <= sub_q + 1'b1;
        end
        S_DATA: if (tick_i) begin
          if (sub_q == SUB_LAST) begin
            sub_q <= '0;
            sh_q  <= {line_i, sh_q[7:1]};
            if (cnt_q == last_idx) state_q <= par_en_i ? S_PAR : S_STOP;
            else                   cnt_q   <= cnt_q + 1'b1;
          end else sub_q <= sub_q + 1'b1;
        end
        S_PAR: if (tick_i) begin
          if (sub_q == SUB_LAST) begin
            sub_q   <= '0;
            par_q   <= line_i;
            state_q <= S_STOP;
          end else sub_q <= sub_q + 1'b1;
        end
        S_STOP: if (tick_i) begin
          if (sub_q == SUB_LAST) begin
            sub_q   <= '0;
            done_o  <= 1'b1;
            data_o  <= aligned;
            fe_o    <= !line_i;
            pe_o    <= par_en_i && (par_q != exp_par);
            state_q <= line_i ? S_IDLE : S_WAIT;
          end else sub_q <= sub_q + 1'b1;
        end
        S_WAIT: if (line_i) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  p_start_abort_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && state_q == S_START && tick_i && sub_q == SUB_HALF && line_i) |=> state_q == S_IDLE);

  p_disabled_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (state_q == S_IDLE && !done_o));

  p_wait_mark_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WAIT && !line_i) |=> state_q != S_START);
endmodule

// File: rtl/async_rx_hold.sv
module async_rx_hold (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       done_i,
  input  logic [7:0] data_i,
  input  logic       fe_i,
  input  logic       pe_i,
  input  logic       rd_i,
  input  logic       clr_i,
  output logic [7:0] data_o,
  output logic       ready_o,
  output logic       fe_o,
  output logic       oe_o,
  output logic       pe_o
);
  logic new_fe, new_pe, new_oe;

  assign new_fe = done_i && fe_i;
  assign new_pe = done_i && pe_i;
  assign new_oe = done_i && ready_o && !rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      ready_o <= 1'b0;
      fe_o    <= 1'b0;
      oe_o    <= 1'b0;
      pe_o    <= 1'b0;
    end else begin
      if (done_i)    data_o  <= data_i;
      if (done_i)    ready_o <= 1'b1;
      else if (rd_i) ready_o <= 1'b0;
      // set beats clear in the same cycle
      fe_o <= (fe_o && !clr_i) || new_fe;
      pe_o <= (pe_o && !clr_i) || new_pe;
      oe_o <= (oe_o && !clr_i) || new_oe;
    end
  end

  p_sticky_fe_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fe_o && !clr_i) |=> fe_o);
  p_sticky_oe_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_o && !clr_i) |=> oe_o);
  p_done_sets_ready_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> (ready_o && data_o == $past(data_i)));
  p_read_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !done_i) |=> !ready_o);
  p_overrun_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && ready_o && !rd_i) |=> oe_o);
endmodule

// File: rtl/async_rx_sticky.sv
module async_rx_sticky #(
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_en_i,
  input  logic       tick_i,
  input  logic       line_i,
  input  logic [1:0] char_len_i,
  input  logic       par_en_i,
  input  logic       par_even_i,
  input  logic       rd_i,
  input  logic       err_clr_i,
  output logic [7:0] data_o,
  output logic [7:0] status_o
);
  logic       line_s;
  logic       done;
  logic [7:0] frame_data;
  logic       frame_fe, frame_pe;
  logic       ready, fe, oe, pe;

  async_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (line_i),
    .q_o   (line_s)
  );

  async_rx_frame #(.OVS(OVS)) u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (rx_en_i),
    .tick_i    (tick_i),
    .line_i    (line_s),
    .len_i     (char_len_i),
    .par_en_i  (par_en_i),
    .par_even_i(par_even_i),
    .done_o    (done),
    .data_o    (frame_data),
    .fe_o      (frame_fe),
    .pe_o      (frame_pe)
  );

  async_rx_hold u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .done_i (done),
    .data_i (frame_data),
    .fe_i   (frame_fe),
    .pe_i   (frame_pe),
    .rd_i   (rd_i),
    .clr_i  (err_clr_i),
    .data_o (data_o),
    .ready_o(ready),
    .fe_o   (fe),
    .oe_o   (oe),
    .pe_o   (pe)
  );

  assign status_o = {2'b00, fe, oe, pe, 1'b0, ready, 1'b0};

  p_status_rsvd_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[7:6] == 2'b00 && status_o[2] == 1'b0 && status_o[0] == 1'b0));
endmodule

// File: tb/async_rx_sticky_bench.sv
module async_rx_sticky_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_en = 1'b0;
  logic       tick = 1'b0;
  logic       line = 1'b1;
  logic [1:0] char_len = 2'b11;
  logic       par_en = 1'b0;
  logic       par_even = 1'b1;
  logic       rd = 1'b0;
  logic       err_clr = 1'b0;
  logic [7:0] data;
  logic [7:0] status;
  int total = 0;
  int fails = 0;

  localparam int BITCLK = 32; // 16 ticks, one tick every 2 clocks

  always #10 clk = ~clk;
  always @(negedge clk) tick <= ~tick;

  async_rx_sticky u_async_rx_sticky (
    .clk_i(clk), .rst_ni(rst_n), .rx_en_i(rx_en), .tick_i(tick), .line_i(line),
    .char_len_i(char_len), .par_en_i(par_en), .par_even_i(par_even),
    .rd_i(rd), .err_clr_i(err_clr), .data_o(data), .status_o(status)
  );

  task automatic check(input logic ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] stat(input logic fe, oe, pe, rdy);
    return {2'b00, fe, oe, pe, 1'b0, rdy, 1'b0};
  endfunction

  task automatic hold_line(input logic v, input int clks);
    line = v;
    repeat (clks) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] ch, input int nbits, input logic with_par,
                      input logic par_bit, input logic stop_bit);
    hold_line(1'b0, BITCLK);
    for (int i = 0; i < nbits; i++) hold_line(ch[i], BITCLK);
    if (with_par) hold_line(par_bit, BITCLK);
    hold_line(stop_bit, BITCLK);
    hold_line(1'b1, BITCLK);
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1;
    @(negedge clk);
    sig = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    check(status == 8'h00, "R11 reset status", status, 8'h00);
    check(data == 8'h00, "R5 reset data", data, 8'h00);
  endtask

  task automatic t_basic8;
    char_len = 2'b11; par_en = 1'b0;
    send(8'hA5, 8, 1'b0, 1'b0, 1'b1);
    check(data == 8'hA5, "R1 8-bit data", data, 8'hA5);
    check(status == stat(0, 0, 0, 1), "R5 ready set", status, stat(0, 0, 0, 1));
    pulse(rd);
    check(status == stat(0, 0, 0, 0), "R6 read clears ready", status, stat(0, 0, 0, 0));
  endtask

  task automatic t_short_even;
    logic [7:0] ch = 8'h13;
    char_len = 2'b00; par_en = 1'b1; par_even = 1'b1;
    send(8'hF3, 5, 1'b1, ^ch[4:0], 1'b1);
    check(data == 8'h13, "R1 5-bit right aligned", data, 8'h13);
    check(status == stat(0, 0, 0, 1), "R3 even parity good", status, stat(0, 0, 0, 1));
    pulse(rd);
  endtask

  task automatic t_parity_sticky;
    char_len = 2'b10; par_en = 1'b1; par_even = 1'b0;
    send(8'h41, 7, 1'b1, ^7'h41, 1'b1); // wrong bit for odd parity
    check(status == stat(0, 0, 1, 1), "R3 odd parity error", status, stat(0, 0, 1, 1));
    pulse(rd);
    send(8'h41, 7, 1'b1, ~^7'h41, 1'b1);
    check(data == 8'h41, "R1 7-bit data", data, 8'h41);
    check(status == stat(0, 0, 1, 1), "R4 parity flag sticky", status, stat(0, 0, 1, 1));
    pulse(rd);
    pulse(err_clr);
    check(status == stat(0, 0, 0, 0), "R4 error clear", status, stat(0, 0, 0, 0));
    par_en = 1'b0; char_len = 2'b11;
    send(8'h5A, 8, 1'b0, 1'b0, 1'b1);
    check(status == stat(0, 0, 0, 1), "R3 no parity check when disabled", status, stat(0, 0, 0, 1));
    pulse(rd);
  endtask

  task automatic t_overrun;
    send(8'h11, 8, 1'b0, 1'b0, 1'b1);
    send(8'h22, 8, 1'b0, 1'b0, 1'b1);
    check(status == stat(0, 1, 0, 1), "R7 overrun flag", status, stat(0, 1, 0, 1));
    check(data == 8'h22, "R7 newer replaces older", data, 8'h22);
    pulse(rd);
    pulse(err_clr);
  endtask

  task automatic t_framing;
    send(8'h7E, 8, 1'b0, 1'b0, 1'b0);
    check(status == stat(1, 0, 0, 1), "R9 framing error", status, stat(1, 0, 0, 1));
    pulse(rd);
    pulse(err_clr);
  endtask

  task automatic t_break;
    hold_line(1'b0, 25 * BITCLK);
    hold_line(1'b1, 2 * BITCLK);
    check(status == stat(1, 0, 0, 1), "R10 break gives one char with framing error", status, stat(1, 0, 0, 1));
    check(data == 8'h00, "R9 break data", data, 8'h00);
    pulse(rd);
    pulse(err_clr);
    send(8'h3C, 8, 1'b0, 1'b0, 1'b1);
    check(data == 8'h3C, "R10 receive after break", data, 8'h3C);
    check(status == stat(0, 0, 0, 1), "R10 clean after break", status, stat(0, 0, 0, 1));
    pulse(rd);
  endtask

  task automatic t_glitch;
    hold_line(1'b0, 8);
    hold_line(1'b1, 3 * BITCLK);
    check(status == stat(0, 0, 0, 0), "R2 short glitch rejected", status, stat(0, 0, 0, 0));
  endtask

  task automatic t_disabled;
    rx_en = 1'b0;
    send(8'h99, 8, 1'b0, 1'b0, 1'b1);
    check(status == stat(0, 0, 0, 0), "R8 disabled receives nothing", status, stat(0, 0, 0, 0));
    rx_en = 1'b1;
    hold_line(1'b1, BITCLK);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    rx_en = 1'b1;
    repeat (4) @(negedge clk);
    t_basic8();
    t_short_even();
    t_parity_sticky();
    t_overrun();
    t_framing();
    t_break();
    t_glitch();
    t_disabled();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule